// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of device interrupt lines and a single CPU interrupt input. Each cycle it chooses the most urgent pending source. It raises a request toward the CPU only when that source outranks the level the CPU is already servicing. Once the CPU acknowledges, the block waits for the selected device to strobe that its identifier is ready. It then returns a vector that the CPU uses to index its handler table. If the device stays silent too long after the acknowledge, the block reports a bus error and drops the transaction.

Levels being serviced are held on a small stack. A higher-priority interrupt can therefore preempt a handler, and each end-of-interrupt pulse brings back the level that was active before. A separate non-maskable input, detected on its rising edge, always wins arbitration and ignores the in-service level, so it can even preempt its own handler.

Top module: `prio_vec_intc`

## Requirements
- R1: While reset is held, and after its release, `cpu_req`, `vec_valid` and `bus_err` are low and the in-service stack is empty.
- R2: Maskable line n has level N_IRQ-n, so a lower index has higher priority. Among lines asserted together the lowest index is selected, and its vector is n+1.
- R3: A selected maskable line whose level is not greater than the top in-service level raises no request. The in-service level is 0 when the stack is empty.
- R4: A rising edge on `nmi_in` is held pending and is delivered with vector 0 at level N_IRQ+1. This happens regardless of the in-service level, including while a non-maskable handler is in service.
- R5: `cpu_req` rises one cycle after a qualifying request is seen and stays high until `cpu_ack` is sampled, then falls. The source is latched when the request is raised, and later arrivals do not change it.
- R6: If `vec_stb` is sampled in any of the ACK_TMO (16) cycles after the acknowledge, `vec_valid` pulses for one cycle with the latched vector on `vec_out`. The source's level is pushed at the same time.
- R7: If `vec_stb` is not seen in those ACK_TMO cycles, `bus_err` pulses for one cycle in the cycle after the last one. Nothing is pushed, and a pending non-maskable edge stays pending.
- R8: An `eoi` pulse pops one level and restores the previous one. An `eoi` pulse with an empty stack has no effect.
- R9: While the stack holds STK_DEPTH levels, no request is raised, not even for a pending non-maskable edge, until an `eoi` frees an entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | N_IRQ | Level-sensitive device requests, index 0 most urgent |
| nmi_in | input | 1 | Non-maskable request, edge-detected |
| eoi | input | 1 | End-of-interrupt pulse, pops one in-service level |
| cpu_ack | input | 1 | CPU acknowledge of `cpu_req` |
| vec_stb | input | 1 | Selected device signals its identifier is ready |
| cpu_req | output | 1 | Interrupt request toward the CPU |
| vec_out | output | clog2(N_IRQ+1) | Vector of the latched source |
| vec_valid | output | 1 | One-cycle strobe qualifying `vec_out` |
| bus_err | output | 1 | One-cycle strobe: no identifier before the timeout |

## Verification
The bench aims at the edges of the acknowledge window. A strobe in the sixteenth cycle must still be accepted, and silence must produce an error exactly one cycle later. A counter that is off by one would either drop a legitimate vector or flag an error early. Equal-or-lower requests arriving during service must stay silent, and a broken compare would let a handler be preempted by its own level. A non-maskable edge must still get through during another non-maskable handler, and a full stack must hold it back until an end-of-interrupt. A changing request set between request and acknowledge must not alter the returned vector. Random request patterns with random end-of-interrupt pulses drive a reference stack in the bench. A design that mishandled underflow or nesting would then return wrong vectors or raise requests that should have been masked.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_WAIT = 2'd2
  } hs_state_t;

endpackage

// File: rtl/intc_select.sv
// Fixed-priority pick among the maskable lines; a pending NMI overrides.
module intc_select #(
  parameter int N_IRQ = 8,
  parameter int VW    = 4,
  parameter int LW    = 4
) (
  input  logic [N_IRQ-1:0] irq,
  input  logic             nmi_pend,
  output logic             sel_any,
  output logic             sel_nmi,
  output logic [VW-1:0]    sel_vec,
  output logic [LW-1:0]    sel_lvl
);

  always_comb begin
    sel_any = 1'b0;
    sel_vec = '0;
    sel_lvl = '0;
    // Walk from least to most urgent so the lowest index is left last.
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (irq[i]) begin
        sel_any = 1'b1;
        sel_vec = VW'(i + 1);
        sel_lvl = LW'(N_IRQ - i);
      end
    end
    sel_nmi = nmi_pend;
    if (nmi_pend) begin
      sel_any = 1'b1;
      sel_vec = '0;
      sel_lvl = LW'(N_IRQ + 1);
    end
  end

endmodule

// File: rtl/intc_lvl_stack.sv
// LIFO of in-service levels. Top level reads 0 when empty.
module intc_lvl_stack #(
  parameter int D  = 4,
  parameter int LW = 4,
  localparam int CW = $clog2(D + 1),
  localparam int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [LW-1:0] push_lvl,
  output logic [LW-1:0] top_lvl,
  output logic [CW-1:0] depth,
  output logic          full
);

  logic [LW-1:0] ent_q [D];
  logic [CW-1:0] dep_q, dep_d, wr_idx;
  logic          pop_eff, push_eff, empty;

  assign empty    = (dep_q == '0);
  assign full     = (dep_q == CW'(D));
  assign pop_eff  = pop & ~empty;
  assign push_eff = push & (~full | pop_eff);

  always_comb begin
    wr_idx = dep_q - CW'(pop_eff);
    dep_d  = dep_q + CW'(push_eff) - CW'(pop_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dep_q <= '0;
    else        dep_q <= dep_d;
  end

  for (genvar k = 0; k < D; k++) begin : g_ent
    logic we;
    assign we = push_eff && (wr_idx == CW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q[k] <= '0;
      else if (we) ent_q[k] <= push_lvl;
    end
  end

  assign top_lvl = empty ? '0 : ent_q[AW'(dep_q - CW'(1))];
  assign depth   = dep_q;

endmodule

// File: rtl/intc_handshake.sv
// Request / acknowledge / identifier handshake with timeout.
module intc_handshake
  import intc_pkg::*;
#(
  parameter int VW  = 4,
  parameter int LW  = 4,
  parameter int TMO = 16,
  localparam int TW = $clog2(TMO)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant,
  input  logic [VW-1:0] sel_vec,
  input  logic [LW-1:0] sel_lvl,
  input  logic          sel_nmi,
  input  logic          cpu_ack,
  input  logic          vec_stb,
  output logic          cpu_req,
  output logic [VW-1:0] vec_out,
  output logic          vec_valid,
  output logic          bus_err,
  output logic          push,
  output logic [LW-1:0] push_lvl,
  output logic          nmi_done
);

  hs_state_t     st_q, st_d;
  logic [VW-1:0] vec_q;
  logic [LW-1:0] lvl_q;
  logic          nmi_q;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en, lat_en;
  logic          valid_q, valid_d, err_q, err_d;

  always_comb begin
    st_d    = st_q;
    lat_en  = 1'b0;
    cnt_en  = 1'b0;
    cnt_d   = cnt_q;
    valid_d = 1'b0;
    err_d   = 1'b0;
    push    = 1'b0;
    case (st_q)
      HS_IDLE: begin
        if (grant) begin
          st_d   = HS_REQ;
          lat_en = 1'b1;
        end
      end
      HS_REQ: begin
        if (cpu_ack) begin
          st_d   = HS_WAIT;
          cnt_en = 1'b1;
          cnt_d  = '0;
        end
      end
      HS_WAIT: begin
        if (vec_stb) begin
          st_d    = HS_IDLE;
          push    = 1'b1;
          valid_d = 1'b1;
        end else if (cnt_q == TW'(TMO - 1)) begin
          st_d  = HS_IDLE;
          err_d = 1'b1;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
        end
      end
      default: st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= HS_IDLE;
      vec_q   <= '0;
      lvl_q   <= '0;
      nmi_q   <= 1'b0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_q <= valid_d;
      err_q   <= err_d;
      if (lat_en) begin
        vec_q <= sel_vec;
        lvl_q <= sel_lvl;
        nmi_q <= sel_nmi;
      end
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cpu_req   = (st_q == HS_REQ);
  assign vec_out   = vec_q;
  assign vec_valid = valid_q;
  assign bus_err   = err_q;
  assign push_lvl  = lvl_q;
  assign nmi_done  = push & nmi_q;

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int N_IRQ     = 8,
  parameter int STK_DEPTH = 4,
  parameter int ACK_TMO   = 16,
  localparam int VW = $clog2(N_IRQ + 1),
  localparam int LW = $clog2(N_IRQ + 2),
  localparam int CW = $clog2(STK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             nmi_in,
  input  logic             eoi,
  input  logic             cpu_ack,
  input  logic             vec_stb,
  output logic             cpu_req,
  output logic [VW-1:0]    vec_out,
  output logic             vec_valid,
  output logic             bus_err
);

  // Reset: asserted asynchronously, released after two clocks.
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // Non-maskable edge capture.
  logic nmi_seen_q, nmi_pend_q, nmi_pend_d, nmi_done;
  always_comb nmi_pend_d = (nmi_pend_q & ~nmi_done) | (nmi_in & ~nmi_seen_q);
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      nmi_seen_q <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_seen_q <= nmi_in;
      nmi_pend_q <= nmi_pend_d;
    end
  end

  logic          sel_any, sel_nmi;
  logic [VW-1:0] sel_vec;
  logic [LW-1:0] sel_lvl, top_lvl, push_lvl;
  logic [CW-1:0] stk_depth;
  logic          stk_full, push, grant;

  intc_select #(.N_IRQ(N_IRQ), .VW(VW), .LW(LW)) u_sel (
    .irq      (irq_in),
    .nmi_pend (nmi_pend_q),
    .sel_any  (sel_any),
    .sel_nmi  (sel_nmi),
    .sel_vec  (sel_vec),
    .sel_lvl  (sel_lvl)
  );

  // Arbitration first, then the compare against the in-service level.
  assign grant = sel_any & (sel_nmi | (sel_lvl > top_lvl)) & ~stk_full;

  intc_lvl_stack #(.D(STK_DEPTH), .LW(LW)) u_stk (
    .clk      (clk),
    .rst_n    (srst_n),
    .push     (push),
    .pop      (eoi),
    .push_lvl (push_lvl),
    .top_lvl  (top_lvl),
    .depth    (stk_depth),
    .full     (stk_full)
  );

  intc_handshake #(.VW(VW), .LW(LW), .TMO(ACK_TMO)) u_hs (
    .clk       (clk),
    .rst_n     (srst_n),
    .grant     (grant),
    .sel_vec   (sel_vec),
    .sel_lvl   (sel_lvl),
    .sel_nmi   (sel_nmi),
    .cpu_ack   (cpu_ack),
    .vec_stb   (vec_stb),
    .cpu_req   (cpu_req),
    .vec_out   (vec_out),
    .vec_valid (vec_valid),
    .bus_err   (bus_err),
    .push      (push),
    .push_lvl  (push_lvl),
    .nmi_done  (nmi_done)
  );

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int N_IRQ     = 8,
  parameter int STK_DEPTH = 4,
  parameter int ACK_TMO   = 16,
  localparam int CW = $clog2(STK_DEPTH + 1),
  localparam int WW = $clog2(ACK_TMO + 2) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_ack,
  input logic          vec_valid,
  input logic          bus_err,
  input logic          eoi,
  input logic          push,
  input logic [CW-1:0] depth,
  input logic          full
);

  // Cycles since the last accepted acknowledge, saturating.
  logic [WW-1:0] wc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wc_q <= '1;
    else if (cpu_req & cpu_ack) wc_q <= '0;
    else if (wc_q != '1)        wc_q <= wc_q + 1'b1;
  end

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_ack |=> cpu_req);
  a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_ack |=> !cpu_req);
  a_r6_push_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> vec_valid);
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err);
  a_r7_err_window: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> wc_q == WW'(ACK_TMO));
  a_r7_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_err && vec_valid));
  a_r8_pop_restores: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && !push && depth != '0 |=> depth == $past(depth) - CW'(1));
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && !push && depth == '0 |=> depth == '0);
  a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_req) |-> !$past(full));

  always_comb begin
    if (rst_n) a_r9_depth_bound: assert (depth <= CW'(STK_DEPTH));
  end

endmodule

bind prio_vec_intc intc_checker #(
  .N_IRQ(N_IRQ), .STK_DEPTH(STK_DEPTH), .ACK_TMO(ACK_TMO)
) u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .cpu_req   (cpu_req),
  .cpu_ack   (cpu_ack),
  .vec_valid (vec_valid),
  .bus_err   (bus_err),
  .eoi       (eoi),
  .push      (push),
  .depth     (stk_depth),
  .full      (stk_full)
);

// File: tb/sim_prio_vec_intc.sv
`timescale 1ns/1ps
module sim_prio_vec_intc;
  localparam int N   = 8;
  localparam int D   = 4;
  localparam int TMO = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] irq;
  logic         nmi, eoi, ack, stb;
  logic         cpu_req, vec_valid, bus_err;
  logic [3:0]   vec_out;

  always #2 clk = ~clk;

  prio_vec_intc #(.N_IRQ(N), .STK_DEPTH(D), .ACK_TMO(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .nmi_in(nmi), .eoi(eoi),
    .cpu_ack(ack), .vec_stb(stb), .cpu_req(cpu_req), .vec_out(vec_out),
    .vec_valid(vec_valid), .bus_err(bus_err)
  );

  int n_chk = 0, n_fail = 0;
  int mstk[D];
  int mcnt = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mtop();
    return (mcnt == 0) ? 0 : mstk[mcnt-1];
  endfunction

  function automatic int pick(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic bit qual(input logic [N-1:0] p);
    int w = pick(p);
    if (w < 0) return 0;
    return ((N - w) > mtop()) && (mcnt < D);
  endfunction

  task automatic mpush(input int lvl);
    if (mcnt < D) begin mstk[mcnt] = lvl; mcnt++; end
  endtask

  task automatic pulse_eoi();
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    if (mcnt > 0) mcnt--;
  endtask

  task automatic drain();
    irq = '0;
    while (mcnt > 0) pulse_eoi();
  endtask

  // Entered at a negedge where cpu_req should be high.
  task automatic serve(input int ev, input int el, input int dly, input string tag);
    bit early = 0;
    chk(cpu_req === 1'b1, "R5 request up before ack", int'(cpu_req), 1);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(cpu_req === 1'b0, "R5 request falls after ack", int'(cpu_req), 0);
    if (dly < TMO) begin
      for (int k = 0; k < dly; k++) @(negedge clk);
      stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      chk(vec_valid === 1'b1 && int'(vec_out) == ev, tag,
          vec_valid ? int'(vec_out) : -1, ev);
      mpush(el);
      @(negedge clk);
      chk(vec_valid === 1'b0, "R6 strobe lasts one cycle", int'(vec_valid), 0);
    end else begin
      for (int k = 1; k < TMO; k++) begin
        @(negedge clk);
        if (bus_err !== 1'b0) early = 1;
      end
      chk(!early, "R7 no error before window ends", int'(early), 0);
      @(negedge clk);
      chk(bus_err === 1'b1 && vec_valid === 1'b0, "R7 bus error after silent window",
          int'(bus_err), 1);
      irq = '0;
      @(negedge clk);
      chk(bus_err === 1'b0, "R7 error lasts one cycle", int'(bus_err), 0);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(7919);
    rst_n = 1'b0; irq = '0; nmi = 1'b0; eoi = 1'b0; ack = 1'b0; stb = 1'b0;
    repeat (3) @(negedge clk);
    chk(cpu_req === 1'b0 && vec_valid === 1'b0 && bus_err === 1'b0,
        "R1 outputs idle in reset", int'(cpu_req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cpu_req === 1'b0 && vec_valid === 1'b0 && bus_err === 1'b0,
        "R1 outputs idle after reset", int'(cpu_req), 0);

    // R8: end-of-interrupt on an empty stack changes nothing.
    pulse_eoi(); pulse_eoi();
    irq = 8'h40; @(negedge clk);
    serve(7, 2, 0, "R1 empty stack accepts line 6");
    irq = 8'hC0; repeat (3) @(negedge clk);
    chk(cpu_req === 1'b0, "R8 empty eoi left level intact, line 7 masked", int'(cpu_req), 0);
    drain();

    // R2: simultaneous lines 3 and 5 -> vector 4.
    irq = 8'h28; @(negedge clk);
    serve(4, 5, 2, "R2 lowest index wins");
    // R3: lower line 5 stays masked while line 3 is in service.
    repeat (3) @(negedge clk);
    chk(cpu_req === 1'b0, "R3 lower line masked", int'(cpu_req), 0);
    // R8: drop line 3, pop -> line 5 now outranks the restored empty level.
    irq = 8'h20; pulse_eoi();
    @(negedge clk);
    serve(6, 3, 1, "R8 previous level restored");
    drain();

    // R5: selection latched; a later higher line arrives before the ack.
    irq = 8'h10; @(negedge clk);
    irq = 8'h12;
    serve(5, 4, 3, "R5 latched vector");
    serve(2, 7, 0, "R2 nested higher line preempts");
    drain();

    // R6 boundary: strobe in the last accepted cycle.
    irq = 8'h08; @(negedge clk);
    serve(4, 5, TMO - 1, "R6 strobe on last window cycle");
    drain();
    // R7: no strobe at all.
    irq = 8'h08; @(negedge clk);
    serve(4, 5, TMO, "R7 timeout");
    irq = 8'h80; @(negedge clk);
    chk(cpu_req === 1'b1, "R7 nothing pushed on error", int'(cpu_req), 1);
    serve(8, 1, 0, "R7 stack still empty");
    drain();

    // R4: NMI preempts line 0, then preempts itself.
    irq = 8'h01; @(negedge clk);
    serve(1, 8, 0, "R2 line 0 vector 1");
    irq = '0;
    for (int r = 0; r < 2; r++) begin
      nmi = 1'b1; @(negedge clk); nmi = 1'b0; @(negedge clk);
      serve(0, N + 1, 3, "R4 NMI vector 0 past mask");
    end
    drain();

    // R9: fill the stack, then NMI must wait for an eoi.
    for (int b = 7; b >= 4; b--) begin
      irq[b] = 1'b1; @(negedge clk);
      serve(b + 1, N - b, 0, "R9 filling stack");
    end
    nmi = 1'b1; @(negedge clk); nmi = 1'b0;
    repeat (5) @(negedge clk);
    chk(cpu_req === 1'b0, "R9 full stack holds NMI", int'(cpu_req), 0);
    irq = '0; pulse_eoi();
    @(negedge clk);
    serve(0, N + 1, 2, "R9 NMI after eoi frees entry");
    drain();

    // Random phase against the reference stack.
    for (int it = 0; it < 300; it++) begin
      logic [N-1:0] p;
      p = N'($urandom);
      if ($urandom % 2) p = p & N'($urandom);
      irq = p;
      @(negedge clk);
      if (qual(p)) begin
        int w, dly;
        w = pick(p);
        chk(cpu_req === 1'b1, "R2 random winner requested", int'(cpu_req), 1);
        dly = ($urandom % 10 == 0) ? TMO : int'($urandom % TMO);
        serve(w + 1, N - w, dly, "R2 random vector");
      end else begin
        chk(cpu_req === 1'b0, (mcnt == D) ? "R9 random full stack" : "R3 random masked",
            int'(cpu_req), 0);
        @(negedge clk);
        chk(cpu_req === 1'b0, "R3 random still masked", int'(cpu_req), 0);
      end
      irq = '0;
      if ($urandom % 2) pulse_eoi();
      else @(negedge clk);
    end
    drain();

    done = 1;
    summary();
    $finish;
  end

endmodule